// File: doc/BRIEF.md
# Hamming Syndrome Decoder and Single-Bit Corrector

This block takes the ECC code computed while a flash page was read and the ECC code stored with it, and decides what went wrong. Each 256-byte chunk of the page carries a 22-bit code. The low 11 bits are line and column parities, and the high 11 bits are their complements. The block XORs the two codes into a syndrome and counts the syndrome's set bits with a registered adder tree. It then sorts the chunk into one of four classes: clean, damaged code only, correctable single-bit data error, or uncorrectable.

For a correctable error the syndrome's low bits name the failing byte and bit directly. When fixing is enabled, the block repairs that bit in an attached page buffer in three steps: it reads the byte, inverts one bit, and writes the byte back. In wide-page mode the block works through every chunk of the page in turn, and the page failure flag is the OR of the chunks' failures. In narrow mode it handles only the first chunk.

The page buffer port is a fixed-latency synchronous memory port with no back-pressure. Read data must be valid on the cycle after `mem_rd_en`, and the memory must accept every `mem_wr_en`. The block has no stream interface. Control and status are plain pins: `start` is honoured only while the block is idle, and the codes and mode inputs are captured on that cycle.

Top module: `hecc_corrector`

## Requirements
- R1: The syndrome is the bitwise XOR of the computed and stored 22-bit codes. A zero syndrome yields status 0 (clean), byte and bit index 0, and no buffer access.
- R2: If either code is all zeros, the chunk is reported clean (status 0) whatever the syndrome is, and the buffer is not touched.
- R3: A syndrome with exactly one bit set yields status 1 (code error). This sets the page failure flag and leaves the buffer unchanged.
- R4: A syndrome with exactly 11 bits set, whose low 11 bits XOR its high 11 bits equal 0x7FF, yields status 2 (corrected). The byte index is syndrome bits [10:3] and the bit index is syndrome bits [2:0]. This does not set the failure flag.
- R5: With fixing enabled, a status-2 chunk has exactly that one bit of that one byte inverted in the buffer. With fixing disabled, the status and indices are reported and the buffer is left alone.
- R6: Every other nonzero syndrome yields status 3 (uncorrectable), sets the failure flag and leaves the buffer unchanged.
- R7: In wide-page mode, chunk 1 uses the second code pair and buffer addresses 256 to 511, and the failure flag is the OR over both chunks. In narrow mode, chunk 1 is not processed: its status reads 0 and no access reaches address 256 or above.
- R8: `done` pulses for one cycle after the last chunk. All results hold until the next accepted `start`, and a `start` during a run is ignored.
- R9: After reset, `done`, `fail`, every status and every index are 0, and no buffer access is issued.
- R10: A repair reads first, then writes the same address two cycles after the read. Read and write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page; accepted only while idle |
| wide_page | input | 1 | 1: process all chunks; 0: chunk 0 only |
| fix_en | input | 1 | Enable in-buffer repair of single-bit errors |
| calc_codes | input | 44 | Computed codes, chunk c in bits [22c+21:22c] |
| stored_codes | input | 44 | Stored codes, same packing |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address (chunk, byte) |
| mem_wdata | output | 8 | Repaired byte |
| mem_rdata | input | 8 | Byte read, valid the cycle after mem_rd_en |
| done | output | 1 | One-cycle end-of-page pulse |
| fail | output | 1 | Page failure: some chunk has status 1 or 3 |
| chunk_status | output | 4 | Per-chunk status, chunk c in bits [2c+1:2c] |
| err_byte | output | 16 | Per-chunk failing byte index |
| err_bit | output | 6 | Per-chunk failing bit index |

## Verification
Some properties are checked on every cycle. The repair write must follow its read by exactly two cycles and change exactly one bit of the byte read. The buffer strobes are never both high, and narrow mode never addresses the upper half. `done` never stays high for two cycles, the adder-tree popcount must match a direct bit count, and the failure flag must agree with the recorded statuses at `done`. Other behaviours only the bench's scenarios can show: the right class for each kind of syndrome, the zero-code override, suppressed repair with fixing disabled, chunk 1 being ignored in narrow mode, results held across idle cycles, and a restart attempted mid-run being refused.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_ECCERR = 2'd1,
    ST_FIXED  = 2'd2,
    ST_UNCORR = 2'd3
  } hecc_status_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SYN,
    SQ_CLS,
    SQ_RD,
    SQ_MOD,
    SQ_WR,
    SQ_FIN
  } hecc_state_e;

endpackage

// File: rtl/hecc_popcount.sv
module hecc_popcount #(
  parameter int W  = 22,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  bits,
  output logic [SW-1:0] count
);
  localparam int LW = $clog2(W);
  localparam int P  = 1 << LW;

  // heap-ordered adder tree: node n sums nodes 2n and 2n+1, leaves at P..2P-1
  logic [SW-1:0] node [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < W) begin : g_real
      assign node[P+i] = SW'(bits[i]);
    end else begin : g_pad
      assign node[P+i] = '0;
    end
  end

  for (genvar n = 1; n < P; n++) begin : g_sum
    assign node[n] = node[2*n] + node[2*n+1];
  end

  assign count = node[1];
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int CODE_W = 2 * LINE_W,
  parameter int PW     = $clog2(CODE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output hecc_status_e      status,
  output logic [LINE_W-1:0] loc
);
  logic [CODE_W-1:0] syn_d, syn_q;
  logic [PW-1:0]     pop_d, pop_q;
  logic              zero_q;
  logic [LINE_W-1:0] pair_diff;

  assign syn_d = calc ^ stored;

  hecc_popcount #(.W(CODE_W), .SW(PW)) u_pop (
    .bits  (syn_d),
    .count (pop_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q  <= '0;
      pop_q  <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      syn_q  <= syn_d;
      pop_q  <= pop_d;
      zero_q <= (calc == '0) || (stored == '0);
    end
  end

  assign pair_diff = syn_q[LINE_W-1:0] ^ syn_q[CODE_W-1:LINE_W];

  always_comb begin
    if (zero_q || (syn_q == '0))
      status = ST_CLEAN;
    else if (pop_q == PW'(1))
      status = ST_ECCERR;
    else if ((pop_q == PW'(LINE_W)) && (pair_diff == '1))
      status = ST_FIXED;
    else
      status = ST_UNCORR;
  end

  assign loc = syn_q[LINE_W-1:0];

  AST_POP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (int'(pop_q) == $countones($past(syn_d)))); // R4
endmodule

// File: rtl/hecc_seq.sv
module hecc_seq
  import hecc_pkg::*;
#(
  parameter int CHUNKS   = 2,
  parameter int CHUNK_AW = 8,
  parameter int DATA_W   = 8,
  parameter int BIT_W    = $clog2(DATA_W),
  parameter int LINE_W   = CHUNK_AW + BIT_W,
  parameter int CIW      = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  parameter int AW       = CHUNK_AW + CIW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_page,
  input  logic              fix_en,
  input  hecc_status_e      status,
  input  logic [LINE_W-1:0] loc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle,
  output logic              load,
  output logic              record,
  output logic [CIW-1:0]    chunk,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);
  hecc_state_e       state_q;
  logic [CIW-1:0]    chunk_q, last_q;
  logic              fix_q, wide_q;
  logic [AW-1:0]     addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] wdata_q;
  logic              repair;

  assign repair = (status == ST_FIXED) && fix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      chunk_q <= '0;
      last_q  <= '0;
      fix_q   <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      bit_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          chunk_q <= '0;
          last_q  <= wide_page ? CIW'(CHUNKS - 1) : '0;
          fix_q   <= fix_en;
          wide_q  <= wide_page;
          state_q <= SQ_SYN;
        end
        SQ_SYN: state_q <= SQ_CLS;
        SQ_CLS: begin
          if (repair) begin
            addr_q  <= {chunk_q, loc[LINE_W-1:BIT_W]};
            bit_q   <= loc[BIT_W-1:0];
            state_q <= SQ_RD;
          end else if (chunk_q == last_q) begin
            state_q <= SQ_FIN;
          end else begin
            chunk_q <= chunk_q + 1'b1;
            state_q <= SQ_SYN;
          end
        end
        SQ_RD:  state_q <= SQ_MOD;
        SQ_MOD: begin
          wdata_q <= mem_rdata ^ (DATA_W'(1) << bit_q);
          state_q <= SQ_WR;
        end
        SQ_WR: begin
          if (chunk_q == last_q) begin
            state_q <= SQ_FIN;
          end else begin
            chunk_q <= chunk_q + 1'b1;
            state_q <= SQ_SYN;
          end
        end
        SQ_FIN:  state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == SQ_IDLE);
  assign load      = (state_q == SQ_SYN);
  assign record    = (state_q == SQ_CLS);
  assign chunk     = chunk_q;
  assign mem_rd_en = (state_q == SQ_RD);
  assign mem_wr_en = (state_q == SQ_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign done      = (state_q == SQ_FIN);

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R10
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en, 2)); // R10
  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wdata ^ $past(mem_rdata)) == 1)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !wide_q) |-> (mem_addr[AW-1:CHUNK_AW] == '0)); // R7
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
  import hecc_pkg::*;
#(
  parameter int CHUNKS   = 2,
  parameter int CHUNK_AW = 8,
  parameter int DATA_W   = 8,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int LINE_W  = CHUNK_AW + BIT_W,
  localparam int CODE_W  = 2 * LINE_W,
  localparam int PW      = $clog2(CODE_W) + 1,
  localparam int CIW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  localparam int AW      = CHUNK_AW + CIW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       wide_page,
  input  logic                       fix_en,
  input  logic [CHUNKS*CODE_W-1:0]   calc_codes,
  input  logic [CHUNKS*CODE_W-1:0]   stored_codes,
  output logic                       mem_rd_en,
  output logic                       mem_wr_en,
  output logic [AW-1:0]              mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       done,
  output logic                       fail,
  output logic [2*CHUNKS-1:0]        chunk_status,
  output logic [CHUNKS*CHUNK_AW-1:0] err_byte,
  output logic [CHUNKS*BIT_W-1:0]    err_bit
);
  logic              idle, load, record, accept;
  logic [CIW-1:0]    chunk;
  hecc_status_e      status;
  logic [LINE_W-1:0] loc;
  logic [CODE_W-1:0] calc_sel, stored_sel;
  logic              fail_q, fail_view;

  logic [CODE_W-1:0] calc_q   [CHUNKS];
  logic [CODE_W-1:0] stored_q [CHUNKS];
  hecc_status_e      stat_q   [CHUNKS];
  logic [LINE_W-1:0] loc_q    [CHUNKS];

  assign accept = start && idle;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        calc_q[c]   <= '0;
        stored_q[c] <= '0;
        stat_q[c]   <= ST_CLEAN;
        loc_q[c]    <= '0;
      end else if (accept) begin
        calc_q[c]   <= calc_codes[c*CODE_W +: CODE_W];
        stored_q[c] <= stored_codes[c*CODE_W +: CODE_W];
        stat_q[c]   <= ST_CLEAN;
        loc_q[c]    <= '0;
      end else if (record && (chunk == CIW'(c))) begin
        stat_q[c] <= status;
        loc_q[c]  <= (status == ST_FIXED) ? loc : '0;
      end
    end

    assign chunk_status[2*c +: 2]              = stat_q[c];
    assign err_byte[c*CHUNK_AW +: CHUNK_AW]    = loc_q[c][LINE_W-1:BIT_W];
    assign err_bit[c*BIT_W +: BIT_W]           = loc_q[c][BIT_W-1:0];
  end

  assign calc_sel   = calc_q[chunk];
  assign stored_sel = stored_q[chunk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fail_q <= 1'b0;
    else if (accept)
      fail_q <= 1'b0;
    else if (record && ((status == ST_ECCERR) || (status == ST_UNCORR)))
      fail_q <= 1'b1;
  end

  assign fail = fail_q;

  hecc_classify #(.LINE_W(LINE_W), .CODE_W(CODE_W), .PW(PW)) u_cls (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .calc   (calc_sel),
    .stored (stored_sel),
    .status (status),
    .loc    (loc)
  );

  hecc_seq #(
    .CHUNKS(CHUNKS), .CHUNK_AW(CHUNK_AW), .DATA_W(DATA_W),
    .BIT_W(BIT_W), .LINE_W(LINE_W), .CIW(CIW), .AW(AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wide_page (wide_page),
    .fix_en    (fix_en),
    .status    (status),
    .loc       (loc),
    .mem_rdata (mem_rdata),
    .idle      (idle),
    .load      (load),
    .record    (record),
    .chunk     (chunk),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done)
  );

  always_comb begin
    fail_view = 1'b0;
    for (int c = 0; c < CHUNKS; c++)
      if ((stat_q[c] == ST_ECCERR) || (stat_q[c] == ST_UNCORR))
        fail_view = 1'b1;
  end

  AST_FAIL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == fail_view)); // R7
endmodule

// File: tb/hecc_corrector_tb_top.sv
`timescale 1ns/1ps
module hecc_corrector_tb_top;

  typedef struct packed {
    logic        wide;
    logic        fix;
    logic [21:0] c0;
    logic [21:0] s0;
    logic [21:0] c1;
    logic [21:0] s1;
    logic [1:0]  e0;
    logic [1:0]  e1;
  } vec_t;

  function automatic logic [21:0] fs(input logic [10:0] l);
    return {~l, l};
  endfunction

  // c* = computed code, s* = syndrome (stored code = c ^ s), e* = expected status
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 22'h1234AB, 22'h000000, 22'h000000, 22'h000000, 2'd0, 2'd0},
    '{1'b0, 1'b1, 22'h2F00F1, 22'h000400, 22'h000000, 22'h000000, 2'd1, 2'd0},
    '{1'b0, 1'b1, 22'h0ABCDE, fs(11'h0A5), 22'h000000, 22'h000000, 2'd2, 2'd0},
    '{1'b0, 1'b0, 22'h155555, fs(11'h7FF), 22'h000000, 22'h000000, 2'd2, 2'd0},
    '{1'b0, 1'b1, 22'h000000, 22'h00F0F0, 22'h000000, 22'h000000, 2'd0, 2'd0},
    '{1'b0, 1'b1, 22'h3C3C3C, 22'h3C3C3C, 22'h000000, 22'h000000, 2'd0, 2'd0},
    '{1'b0, 1'b1, 22'h111111, 22'h000003, 22'h000000, 22'h000000, 2'd3, 2'd0},
    '{1'b0, 1'b1, 22'h222222, fs(11'h000), 22'h000000, 22'h000000, 2'd2, 2'd0},
    '{1'b0, 1'b1, 22'h0F0F0F, 22'h0017FE, 22'h000000, 22'h000000, 2'd3, 2'd0},
    '{1'b1, 1'b1, 22'h0C0C0C, 22'h000000, 22'h1A2B3C, fs(11'h123), 2'd0, 2'd2},
    '{1'b1, 1'b1, 22'h0D0D0D, fs(11'h3FF), 22'h1B1B1B, 22'h000003, 2'd2, 2'd3},
    '{1'b0, 1'b1, 22'h0E0E0E, 22'h000000, 22'h1C1C1C, 22'h000003, 2'd0, 2'd3},
    '{1'b1, 1'b1, 22'h070707, 22'h100000, 22'h060606, 22'h000000, 2'd1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide_page = 1'b0;
  logic        fix_en = 1'b0;
  logic [43:0] calc_codes = '0;
  logic [43:0] stored_codes = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done, fail;
  logic [3:0]  chunk_status;
  logic [15:0] err_byte;
  logic [5:0]  err_bit;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hecc_corrector dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .wide_page    (wide_page),
    .fix_en       (fix_en),
    .calc_codes   (calc_codes),
    .stored_codes (stored_codes),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .done         (done),
    .fail         (fail),
    .chunk_status (chunk_status),
    .err_byte     (err_byte),
    .err_bit      (err_bit)
  );

  // page buffer model: registered read, one cycle latency
  logic [7:0] mem [512];
  logic [7:0] shadow [512];
  logic       init_req = 1'b0;
  int         wr_cnt;
  int         cyc;
  int         rd_cyc;
  int         last_gap;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_req) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
      wr_cnt   <= 0;
      last_gap <= -1;
    end else begin
      if (mem_rd_en) begin
        mem_rdata <= mem[mem_addr];
        rd_cyc    <= cyc;
      end
      if (mem_wr_en) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt        <= wr_cnt + 1;
        last_gap      <= cyc - rd_cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] st, input logic [21:0] c,
                                   input logic [21:0] s);
    if (st == 2'd0) return ((c == 0) || ((c ^ s) == 0)) ? "R2" : "R1";
    if (st == 2'd1) return "R3";
    if (st == 2'd2) return "R4";
    return "R6";
  endfunction

  task automatic init_buf();
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
    for (int i = 0; i < 512; i++) shadow[i] = pat(i);
  endtask

  task automatic drive(input vec_t v);
    wide_page    = v.wide;
    fix_en       = v.fix;
    calc_codes   = {v.c1, v.c0};
    stored_codes = {v.c1 ^ v.s1, v.c0 ^ v.s0};
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic verify(input vec_t v);
    logic [1:0] e1;
    logic [7:0] eb0, eb1;
    logic [2:0] et0, et1;
    bit         efail;
    int         ewr, bad;
    e1    = v.wide ? v.e1 : 2'd0;
    eb0   = (v.e0 == 2'd2) ? v.s0[10:3] : 8'd0;
    et0   = (v.e0 == 2'd2) ? v.s0[2:0]  : 3'd0;
    eb1   = (e1 == 2'd2) ? v.s1[10:3] : 8'd0;
    et1   = (e1 == 2'd2) ? v.s1[2:0]  : 3'd0;
    efail = (v.e0 == 2'd1) || (v.e0 == 2'd3) || (e1 == 2'd1) || (e1 == 2'd3);
    ewr   = 0;
    if (v.fix && v.e0 == 2'd2) begin
      shadow[{1'b0, eb0}] = shadow[{1'b0, eb0}] ^ (8'd1 << et0); ewr++;
    end
    if (v.fix && e1 == 2'd2) begin
      shadow[{1'b1, eb1}] = shadow[{1'b1, eb1}] ^ (8'd1 << et1); ewr++;
    end
    chk(chunk_status[1:0] == v.e0, tag_of(v.e0, v.c0, v.s0), "chunk0 status", chunk_status[1:0], v.e0);
    chk(chunk_status[3:2] == e1, "R7", "chunk1 status", chunk_status[3:2], e1);
    chk({err_byte[7:0], err_bit[2:0]} == {eb0, et0}, "R4", "chunk0 location",
        {err_byte[7:0], err_bit[2:0]}, {eb0, et0});
    chk({err_byte[15:8], err_bit[5:3]} == {eb1, et1}, "R7", "chunk1 location",
        {err_byte[15:8], err_bit[5:3]}, {eb1, et1});
    chk(fail == efail, "R7", "page fail flag", fail, efail);
    chk(wr_cnt == ewr, "R5", "buffer write count", wr_cnt, ewr);
    if (ewr > 0) chk(last_gap == 2, "R10", "read-to-write spacing", last_gap, 2);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, "R5", "buffer bytes differing from expected", bad, 0);
  endtask

  task automatic run_vec(input vec_t v);
    bit got;
    init_buf();
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(got);
    chk(got, "R8", "done seen", got, 1);
    @(negedge clk);
    chk(!done, "R8", "done width one cycle", done, 0);
    verify(v);
  endtask

  initial begin
    bit got;
    logic [3:0]  h_st;
    logic [15:0] h_by;
    logic [5:0]  h_bi;
    logic        h_f;
    repeat (3) @(negedge clk);
    chk(!done && !fail, "R9", "done/fail at reset", {done, fail}, 0);
    chk(chunk_status == 0 && err_byte == 0 && err_bit == 0, "R9", "results at reset",
        {chunk_status, err_byte, err_bit}, 0);
    chk(!mem_rd_en && !mem_wr_en, "R9", "buffer strobes at reset", {mem_rd_en, mem_wr_en}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // results hold while idle and inputs change (R8)
    run_vec(VECS[10]);
    h_st = chunk_status; h_by = err_byte; h_bi = err_bit; h_f = fail;
    drive(VECS[0]);
    repeat (12) @(negedge clk);
    chk({chunk_status, err_byte, err_bit, fail} == {h_st, h_by, h_bi, h_f}, "R8",
        "results held while idle", {chunk_status, err_byte, err_bit, fail},
        {h_st, h_by, h_bi, h_f});

    // start during a run is ignored: first page's results stand (R8)
    init_buf();
    @(negedge clk);
    drive(VECS[9]);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (2) @(negedge clk);
    drive(VECS[6]);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(got);
    chk(got, "R8", "done seen with mid-run start", got, 1);
    @(negedge clk);
    verify(VECS[9]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule